// File: doc/BRIEF.md
# Effective-Address Sequencer for an 8-bit Accumulator CPU

This block turns the low opcode bits of an 8-bit accumulator machine into an operand address. Bits 1:0 of the opcode pick an operation group and bits 4:2 pick a selector. The same selector means a different addressing mode in each group. After a one-cycle `start`, the block captures the opcode bits, index registers, operand address and read/write form. It then fetches operand bytes and, for the indirect modes, a little-endian pointer through a byte-wide read port. When the address is ready it pulses `done`.

The read port uses a valid/ready request. `mem_rd_valid` and `mem_rd_addr` stay unchanged until `mem_rd_ready` is sampled high at a clock edge. The byte is returned on `mem_rd_data` in the cycle after that acceptance. The port never has more than one request outstanding. A slow memory applies back-pressure by holding ready low, and the sequence then stretches by one cycle per stalled cycle. Execution, the ALU, the stack, interrupts and opcode fetch belong to other blocks.

Top module: `ea_sequencer`

## Requirements
- R1: With opcode bits 1:0 = 01, selectors 0 to 7 give in turn: pre-indexed zero-page indirect by X, zero page, immediate, absolute, post-indexed zero-page indirect by Y, zero page+X, absolute+Y, absolute+X.
- R2: With bits 1:0 = 00, selectors 0, 1, 3, 5 and 7 give immediate, zero page, absolute, zero page+X and absolute+X. Selectors 2, 4 and 6, and every selector with bits 1:0 = 11, raise `illegal_mode`.
- R3: With bits 1:0 = 10, selector 2 raises `acc_target` and the other selectors behave as in R2. When `y_index` is 1, selector 5 becomes zero page+Y and selector 7 becomes absolute+Y.
- R4: Zero-page modes use one operand byte as the low address byte and place 0x00 in the high byte. In the indexed forms, X or Y is added to the low byte only, so the result wraps at 0xFF and stays in page zero.
- R5: Absolute modes read the low byte at `op_addr` and the high byte at `op_addr`+1. The indexed forms add X or Y to the full 16-bit value, modulo 2^16.
- R6: In the pre-indexed indirect mode, the operand byte plus X (mod 256) gives a page-zero pointer address. The pointer's low byte is read there and its high byte at that address+1 (mod 256). The pointer is the effective address.
- R7: In the post-indexed indirect mode, the operand byte is the page-zero pointer address, read the same way with the same wrap. Y is then added to the full 16-bit pointer.
- R8: `page_penalty` is 1 only when `rd_form` is 1, the mode is absolute+X, absolute+Y or post-indexed indirect, and the effective high byte differs from the high byte of the base address.
- R9: Immediate mode gives `eff_addr` = `op_addr` and raises `imm_operand`. Immediate, accumulator and illegal modes issue no memory request. Accumulator and illegal modes give `eff_addr` = 0.
- R10: The port issues reads in this order: operand low byte, operand high byte, pointer low byte, pointer high byte, skipping any the mode does not need. A request holds its address until it is accepted. Data is taken one cycle after acceptance.
- R11: `done` is high for one cycle. That cycle is one cycle after `start` for modes with no fetch, or two cycles after the last accepted request otherwise. Outputs hold until the next accepted start. The inputs are sampled only at an accepted start. A `start` while busy is ignored.
- R12: Synchronous active-high `rst` returns the block to idle, with `done` and `mem_rd_valid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle launch pulse |
| opcode_lo | input | 5 | Opcode bits 4:0 (selector 4:2, group 1:0) |
| y_index | input | 1 | Selects the Y-indexed variant of group 10 |
| rd_form | input | 1 | 1 = read form (penalty allowed) |
| idx_x | input | DW | X index register |
| idx_y | input | DW | Y index register |
| op_addr | input | 2*DW | Address of the first operand byte |
| mem_rd_valid | output | 1 | Read request valid |
| mem_rd_ready | input | 1 | Read request accepted |
| mem_rd_addr | output | 2*DW | Read request address |
| mem_rd_data | input | DW | Read data, one cycle after acceptance |
| done | output | 1 | One-cycle completion pulse |
| eff_addr | output | 2*DW | Effective address |
| acc_target | output | 1 | Operand is the accumulator |
| imm_operand | output | 1 | Operand is the immediate byte |
| page_penalty | output | 1 | Extra cycle needed for a page cross |
| illegal_mode | output | 1 | Selector is illegal in its group |

## Verification
The bench builds the block with its default byte width, DW = 8. At that width, page-zero wraps at 0xFF and pointer reads that straddle 0xFF/0x00 can be reached with chosen bytes. So can carries from the low byte into the high byte, and a 16-bit sum that passes 0xFFFF. Pseudo-random stalls on `mem_rd_ready` exercise the request hold and the timing of `done` against acceptance.

// File: rtl/amseq_pkg.sv
`timescale 1ns/1ps
package amseq_pkg;

  typedef enum logic [3:0] {
    AM_IMM, AM_ZP, AM_ZPX, AM_ZPY, AM_ABS, AM_ABX, AM_ABY,
    AM_IZX, AM_IZY, AM_ACC, AM_ILL
  } am_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_OP_LO, ST_OP_HI, ST_PTR_LO, ST_PTR_HI
  } seq_st_e;

  // selector and group field positions inside the opcode
  localparam int SEL_MSB = 4;
  localparam int SEL_LSB = 2;
  localparam int GRP_MSB = 1;

  function automatic logic mode_fetches(am_mode_e m);
    return !(m == AM_IMM || m == AM_ACC || m == AM_ILL);
  endfunction

  function automatic logic mode_two_byte(am_mode_e m);
    return (m == AM_ABS || m == AM_ABX || m == AM_ABY);
  endfunction

  function automatic logic mode_indirect(am_mode_e m);
    return (m == AM_IZX || m == AM_IZY);
  endfunction

  function automatic logic mode_may_penalise(am_mode_e m);
    return (m == AM_ABX || m == AM_ABY || m == AM_IZY);
  endfunction

endpackage

// File: rtl/amseq_decode.sv
`timescale 1ns/1ps
module amseq_decode
  import amseq_pkg::*;
(
  input  logic [SEL_MSB:0] opc,
  input  logic             y_index,
  output am_mode_e         mode
);
  logic [GRP_MSB:0] grp;
  logic [SEL_MSB-SEL_LSB:0] sel;

  always_comb begin
    grp  = opc[GRP_MSB:0];
    sel  = opc[SEL_MSB:SEL_LSB];
    mode = AM_ILL;
    case (grp)
      2'b01: begin
        case (sel)
          3'd0: mode = AM_IZX;
          3'd1: mode = AM_ZP;
          3'd2: mode = AM_IMM;
          3'd3: mode = AM_ABS;
          3'd4: mode = AM_IZY;
          3'd5: mode = AM_ZPX;
          3'd6: mode = AM_ABY;
          default: mode = AM_ABX;
        endcase
      end
      2'b00, 2'b10: begin
        case (sel)
          3'd0: mode = AM_IMM;
          3'd1: mode = AM_ZP;
          3'd2: mode = (grp == 2'b10) ? AM_ACC : AM_ILL;
          3'd3: mode = AM_ABS;
          3'd5: mode = (grp == 2'b10 && y_index) ? AM_ZPY : AM_ZPX;
          3'd7: mode = (grp == 2'b10 && y_index) ? AM_ABY : AM_ABX;
          default: mode = AM_ILL;
        endcase
      end
      default: mode = AM_ILL;
    endcase
  end
endmodule

// File: rtl/amseq_addr_calc.sv
`timescale 1ns/1ps
module amseq_addr_calc
  import amseq_pkg::*;
#(
  parameter int DW = 8,
  localparam int AW = 2 * DW
)(
  input  am_mode_e        mode,
  input  logic [AW-1:0]   base_pc,
  input  logic [DW-1:0]   op_lo,
  input  logic [DW-1:0]   op_hi,
  input  logic [DW-1:0]   ptr_lo,
  input  logic [DW-1:0]   ptr_hi,
  input  logic [DW-1:0]   idx_x,
  input  logic [DW-1:0]   idx_y,
  input  logic            rd_form,
  output logic [AW-1:0]   ptr_addr,
  output logic [AW-1:0]   ptr_addr_nxt,
  output logic [AW-1:0]   eff_addr,
  output logic            cross_pen
);
  localparam logic [DW-1:0] PAGE0 = '0;

  logic [DW-1:0] zp_ptr, zp_ptr_nxt, zp_sum_x, zp_sum_y;
  logic [AW-1:0] base, offs;

  always_comb begin
    zp_sum_x   = op_lo + idx_x;
    zp_sum_y   = op_lo + idx_y;
    zp_ptr     = (mode == AM_IZX) ? zp_sum_x : op_lo;
    zp_ptr_nxt = zp_ptr + DW'(1);
    ptr_addr     = {PAGE0, zp_ptr};
    ptr_addr_nxt = {PAGE0, zp_ptr_nxt};

    base = '0;
    offs = '0;
    case (mode)
      AM_IMM: base = base_pc;
      AM_ZP:  base = {PAGE0, op_lo};
      AM_ZPX: base = {PAGE0, zp_sum_x};
      AM_ZPY: base = {PAGE0, zp_sum_y};
      AM_ABS: base = {op_hi, op_lo};
      AM_ABX: begin base = {op_hi, op_lo};   offs = {PAGE0, idx_x}; end
      AM_ABY: begin base = {op_hi, op_lo};   offs = {PAGE0, idx_y}; end
      AM_IZX: base = {ptr_hi, ptr_lo};
      AM_IZY: begin base = {ptr_hi, ptr_lo}; offs = {PAGE0, idx_y}; end
      default: base = '0;
    endcase
    eff_addr  = base + offs;
    cross_pen = rd_form && mode_may_penalise(mode) &&
                (eff_addr[AW-1:DW] != base[AW-1:DW]);
  end
endmodule

// File: rtl/amseq_fetch_seq.sv
`timescale 1ns/1ps
module amseq_fetch_seq
  import amseq_pkg::*;
#(
  parameter int DW = 8,
  localparam int AW = 2 * DW
)(
  input  logic          clk,
  input  logic          rst,
  input  logic          take,
  input  am_mode_e      mode_dec,
  input  logic [AW-1:0] pc,
  input  logic [AW-1:0] ptr_addr,
  input  logic [AW-1:0] ptr_addr_nxt,
  output logic          rd_valid,
  input  logic          rd_ready,
  output logic [AW-1:0] rd_addr,
  input  logic [DW-1:0] rd_data,
  output am_mode_e      mode_q,
  output logic [DW-1:0] op_lo,
  output logic [DW-1:0] op_hi,
  output logic [DW-1:0] ptr_lo,
  output logic [DW-1:0] ptr_hi,
  output logic          busy,
  output logic          done_q
);
  seq_st_e st;
  logic    pend;

  always_comb begin
    busy     = (st != ST_IDLE);
    rd_valid = busy && !pend;
    case (st)
      ST_OP_LO:  rd_addr = pc;
      ST_OP_HI:  rd_addr = pc + AW'(1);
      ST_PTR_LO: rd_addr = ptr_addr;
      ST_PTR_HI: rd_addr = ptr_addr_nxt;
      default:   rd_addr = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_IDLE;
      pend   <= 1'b0;
      done_q <= 1'b0;
      mode_q <= AM_ILL;
      op_lo  <= '0;
      op_hi  <= '0;
      ptr_lo <= '0;
      ptr_hi <= '0;
    end else begin
      done_q <= 1'b0;
      if (st == ST_IDLE) begin
        if (take) begin
          mode_q <= mode_dec;
          if (mode_fetches(mode_dec)) st <= ST_OP_LO;
          else done_q <= 1'b1;
        end
      end else if (pend) begin
        pend <= 1'b0;
        case (st)
          ST_OP_LO: begin
            op_lo <= rd_data;
            if (mode_two_byte(mode_q))      st <= ST_OP_HI;
            else if (mode_indirect(mode_q)) st <= ST_PTR_LO;
            else begin st <= ST_IDLE; done_q <= 1'b1; end
          end
          ST_OP_HI: begin
            op_hi  <= rd_data;
            st     <= ST_IDLE;
            done_q <= 1'b1;
          end
          ST_PTR_LO: begin
            ptr_lo <= rd_data;
            st     <= ST_PTR_HI;
          end
          default: begin
            ptr_hi <= rd_data;
            st     <= ST_IDLE;
            done_q <= 1'b1;
          end
        endcase
      end else if (rd_valid && rd_ready) begin
        pend <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/ea_sequencer.sv
`timescale 1ns/1ps
module ea_sequencer
  import amseq_pkg::*;
#(
  parameter int DW = 8,
  localparam int AW = 2 * DW
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [SEL_MSB:0]  opcode_lo,
  input  logic              y_index,
  input  logic              rd_form,
  input  logic [DW-1:0]     idx_x,
  input  logic [DW-1:0]     idx_y,
  input  logic [AW-1:0]     op_addr,
  output logic              mem_rd_valid,
  input  logic              mem_rd_ready,
  output logic [AW-1:0]     mem_rd_addr,
  input  logic [DW-1:0]     mem_rd_data,
  output logic              done,
  output logic [AW-1:0]     eff_addr,
  output logic              acc_target,
  output logic              imm_operand,
  output logic              page_penalty,
  output logic              illegal_mode
);
  am_mode_e      mode_dec, mode_q;
  logic          busy, take, rd_q;
  logic [DW-1:0] x_q, y_q, op_lo, op_hi, ptr_lo, ptr_hi;
  logic [AW-1:0] pc_q, ptr_a, ptr_a_nxt;

  assign take = start && !busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      x_q  <= '0;
      y_q  <= '0;
      pc_q <= '0;
      rd_q <= 1'b0;
    end else if (take) begin
      x_q  <= idx_x;
      y_q  <= idx_y;
      pc_q <= op_addr;
      rd_q <= rd_form;
    end
  end

  amseq_decode u_decode (
    .opc     (opcode_lo),
    .y_index (y_index),
    .mode    (mode_dec)
  );

  amseq_fetch_seq #(.DW(DW)) u_seq (
    .clk          (clk),
    .rst          (rst),
    .take         (take),
    .mode_dec     (mode_dec),
    .pc           (pc_q),
    .ptr_addr     (ptr_a),
    .ptr_addr_nxt (ptr_a_nxt),
    .rd_valid     (mem_rd_valid),
    .rd_ready     (mem_rd_ready),
    .rd_addr      (mem_rd_addr),
    .rd_data      (mem_rd_data),
    .mode_q       (mode_q),
    .op_lo        (op_lo),
    .op_hi        (op_hi),
    .ptr_lo       (ptr_lo),
    .ptr_hi       (ptr_hi),
    .busy         (busy),
    .done_q       (done)
  );

  amseq_addr_calc #(.DW(DW)) u_calc (
    .mode         (mode_q),
    .base_pc      (pc_q),
    .op_lo        (op_lo),
    .op_hi        (op_hi),
    .ptr_lo       (ptr_lo),
    .ptr_hi       (ptr_hi),
    .idx_x        (x_q),
    .idx_y        (y_q),
    .rd_form      (rd_q),
    .ptr_addr     (ptr_a),
    .ptr_addr_nxt (ptr_a_nxt),
    .eff_addr     (eff_addr),
    .cross_pen    (page_penalty)
  );

  assign acc_target   = (mode_q == AM_ACC);
  assign imm_operand  = (mode_q == AM_IMM);
  assign illegal_mode = (mode_q == AM_ILL);
endmodule

// File: rtl/ea_sequencer_chk.sv
`timescale 1ns/1ps
module ea_sequencer_chk
  import amseq_pkg::*;
#(
  parameter int DW = 8,
  localparam int AW = 2 * DW
)(
  input logic          clk,
  input logic          rst,
  input logic          busy,
  input logic          rd_q,
  input am_mode_e      mode_q,
  input logic          mem_rd_valid,
  input logic          mem_rd_ready,
  input logic [AW-1:0] mem_rd_addr,
  input logic          done,
  input logic [AW-1:0] eff_addr,
  input logic          acc_target,
  input logic          imm_operand,
  input logic          page_penalty,
  input logic          illegal_mode
);
  // R10: a stalled request keeps valid and address
  a_r10_hold_request: assert property (@(posedge clk) disable iff (rst)
    mem_rd_valid && !mem_rd_ready |=> mem_rd_valid && $stable(mem_rd_addr));

  // R8: write forms never carry the penalty
  a_r8_write_no_penalty: assert property (@(posedge clk) disable iff (rst)
    done && !rd_q |-> !page_penalty);

  // R4: zero-page results stay in page zero
  a_r4_zp_page_zero: assert property (@(posedge clk) disable iff (rst)
    done && (mode_q == AM_ZP || mode_q == AM_ZPX || mode_q == AM_ZPY)
      |-> eff_addr[AW-1:DW] == '0);

  // R9: at most one operand-kind flag
  a_r9_kind_flags: assert property (@(posedge clk) disable iff (rst)
    done |-> $onehot0({acc_target, imm_operand, illegal_mode}));

  // R11: no request while idle
  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mem_rd_valid);

  // R12: first cycle after reset is quiet
  a_r12_reset_quiet: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !done && !mem_rd_valid);
endmodule

bind ea_sequencer ea_sequencer_chk #(.DW(DW)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .busy         (busy),
  .rd_q         (rd_q),
  .mode_q       (mode_q),
  .mem_rd_valid (mem_rd_valid),
  .mem_rd_ready (mem_rd_ready),
  .mem_rd_addr  (mem_rd_addr),
  .done         (done),
  .eff_addr     (eff_addr),
  .acc_target   (acc_target),
  .imm_operand  (imm_operand),
  .page_penalty (page_penalty),
  .illegal_mode (illegal_mode)
);

// File: tb/test_ea_sequencer.sv
`timescale 1ns/1ps
module test_ea_sequencer;
  localparam int DW = 8;
  localparam int AW = 16;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst = 1'b1, start = 1'b0, y_index = 1'b0, rd_form = 1'b0;
  logic [4:0]    opcode_lo = '0;
  logic [DW-1:0] idx_x = '0, idx_y = '0, mem_rd_data = '0;
  logic [AW-1:0] op_addr = '0, mem_rd_addr, eff_addr;
  logic          mem_rd_valid, mem_rd_ready = 1'b0, done;
  logic          acc_target, imm_operand, page_penalty, illegal_mode;

  ea_sequencer #(.DW(DW)) i_ea_sequencer (
    .clk(clk), .rst(rst), .start(start), .opcode_lo(opcode_lo),
    .y_index(y_index), .rd_form(rd_form), .idx_x(idx_x), .idx_y(idx_y),
    .op_addr(op_addr), .mem_rd_valid(mem_rd_valid),
    .mem_rd_ready(mem_rd_ready), .mem_rd_addr(mem_rd_addr),
    .mem_rd_data(mem_rd_data), .done(done), .eff_addr(eff_addr),
    .acc_target(acc_target), .imm_operand(imm_operand),
    .page_penalty(page_penalty), .illegal_mode(illegal_mode)
  );

  int nchk = 0, nerr = 0;
  logic [7:0] ovr [int];
  logic [7:0] lf = 8'hA5;
  logic       acc_flag = 1'b0;
  int         acc_addr = 0;

  function automatic logic [7:0] memv(int a);
    int b = a & 16'hFFFF;
    if (ovr.exists(b)) return ovr[b];
    return 8'((b * 37) ^ (b >> 8) ^ 8'h5A);
  endfunction

  // byte returned one cycle after an accepted request
  always @(posedge clk) if (acc_flag) mem_rd_data <= memv(acc_addr);

  function automatic logic next_ready();
    lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
    return lf[1:0] != 2'b00;
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic run_op(string req, int grp, int sel, bit yv, bit rd,
                        int x, int y, int pc, bit poke);
    string t01[8] = '{"IZX","ZP","IMM","ABS","IZY","ZPX","ABY","ABX"};
    string m;
    int q[$];
    int lo, hi, p, base, add, ea = 0, nf, cyc = 0, last = -10;
    bit pen = 0, e_acc = 0, e_imm = 0, e_ill = 0, seen = 0;
    if (grp == 1) m = t01[sel];
    else if (grp == 3) m = "ILL";
    else case (sel)
      0: m = "IMM";
      1: m = "ZP";
      2: m = (grp == 2) ? "ACC" : "ILL";
      3: m = "ABS";
      5: m = (grp == 2 && yv) ? "ZPY" : "ZPX";
      7: m = (grp == 2 && yv) ? "ABY" : "ABX";
      default: m = "ILL";
    endcase
    lo = memv(pc); hi = memv(pc + 1);
    case (m)
      "IMM": begin ea = pc; e_imm = 1; end
      "ACC": e_acc = 1;
      "ILL": e_ill = 1;
      "ZP":  begin q = '{pc}; ea = lo; end
      "ZPX": begin q = '{pc}; ea = (lo + x) & 255; end
      "ZPY": begin q = '{pc}; ea = (lo + y) & 255; end
      "ABS", "ABX", "ABY": begin
        q = '{pc, (pc + 1) & 16'hFFFF};
        base = hi * 256 + lo;
        add = (m == "ABX") ? x : (m == "ABY") ? y : 0;
        ea = (base + add) & 16'hFFFF;
        pen = rd && m != "ABS" && ((ea >> 8) != (base >> 8));
      end
      default: begin
        p = (m == "IZX") ? ((lo + x) & 255) : lo;
        q = '{pc, p, (p + 1) & 255};
        base = memv((p + 1) & 255) * 256 + memv(p);
        ea = (m == "IZY") ? ((base + y) & 16'hFFFF) : base;
        pen = rd && m == "IZY" && ((ea >> 8) != (base >> 8));
      end
    endcase
    nf = q.size();

    @(posedge clk); #1;
    start = 1; opcode_lo = 5'((sel << 2) | grp); y_index = yv; rd_form = rd;
    idx_x = 8'(x); idx_y = 8'(y); op_addr = 16'(pc); mem_rd_ready = next_ready();
    while (!seen && cyc < 80) begin
      @(negedge clk);
      acc_flag = 1'b0;
      if (mem_rd_valid) begin
        if (q.size() == 0) chk("R10", "unexpected request", 1, 0);
        else if (mem_rd_ready) begin
          chk("R10", "request address", mem_rd_addr, q[0]);
          void'(q.pop_front());
          acc_flag = 1'b1; acc_addr = mem_rd_addr; last = cyc;
        end
      end
      if (done) begin
        seen = 1;
        chk("R11", "done cycle", cyc, (nf == 0) ? 1 : last + 2);
        chk("R10", "fetches left", q.size(), 0);
        chk(req, {m, " eff_addr"}, eff_addr, ea);
        chk("R8", {m, " penalty"}, page_penalty, pen);
        chk("R9", {m, " acc flag"}, acc_target, e_acc);
        chk("R9", {m, " imm flag"}, imm_operand, e_imm);
        chk(req, {m, " illegal flag"}, illegal_mode, e_ill);
      end
      @(posedge clk); #1;
      // inputs change after start; R11: a busy start and new inputs are ignored
      start = (poke && cyc == 0) ? 1'b1 : 1'b0;
      if (cyc == 0) begin
        idx_x = ~idx_x; idx_y = ~idx_y; op_addr = ~op_addr; rd_form = ~rd_form;
        opcode_lo = 5'b01001;
      end
      mem_rd_ready = next_ready();
      cyc++;
    end
    if (!seen) chk("R11", "done seen", 0, 1);
    @(negedge clk);
    acc_flag = 1'b0;
    chk("R11", "done single pulse", done, 0);
    chk("R11", "eff_addr held", eff_addr, ea);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nerr++;
    $display("FAIL R11 watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R12", "done in reset", done, 0);
    chk("R12", "valid in reset", mem_rd_valid, 0);
    @(posedge clk); #1 rst = 0;
    @(negedge clk);
    chk("R12", "done after reset", done, 0);
    chk("R12", "valid after reset", mem_rd_valid, 0);

    for (int s = 0; s < 8; s++) run_op("R1", 1, s, 0, 1, 8'h05, 8'h07, 16'h0300 + s * 4, 0);
    for (int s = 0; s < 8; s++) run_op("R2", 0, s, 0, 1, 8'h11, 8'h22, 16'h0340 + s * 4, 0);
    for (int s = 0; s < 8; s++) run_op("R3", 2, s, 0, 1, 8'h33, 8'h44, 16'h0380 + s * 4, 0);
    for (int s = 0; s < 8; s++) run_op("R3", 2, s, 1, 0, 8'h33, 8'h44, 16'h03C0 + s * 4, 0);
    for (int s = 0; s < 8; s += 3) run_op("R2", 3, s, 1, 1, 8'h01, 8'h02, 16'h0420, 0);
    run_op("R9", 1, 2, 0, 1, 0, 0, 16'hFFFF, 0);

    // R4: zero-page indexed wrap
    ovr[16'h0400] = 8'hF0;
    run_op("R4", 1, 5, 0, 1, 8'h20, 8'h00, 16'h0400, 0);
    run_op("R4", 2, 5, 1, 1, 8'h00, 8'h30, 16'h0400, 0);
    // R5 and R8: absolute carry, write form, 16-bit wrap
    ovr[16'h0500] = 8'hF0; ovr[16'h0501] = 8'h12;
    run_op("R5", 1, 7, 0, 1, 8'h20, 8'h00, 16'h0500, 0);
    run_op("R5", 1, 7, 0, 0, 8'h20, 8'h00, 16'h0500, 0);
    run_op("R5", 1, 6, 0, 1, 8'h00, 8'h05, 16'h0500, 0);
    ovr[16'h0510] = 8'hF0; ovr[16'h0511] = 8'hFF;
    run_op("R5", 0, 7, 0, 1, 8'h20, 8'h00, 16'h0510, 0);
    run_op("R5", 2, 3, 0, 1, 8'h00, 8'h00, 16'hFFFF, 0);
    // R6: pre-indexed pointer at 0x00 and straddling 0xFF
    ovr[16'h0000] = 8'h34; ovr[16'h0001] = 8'h12; ovr[16'h00FF] = 8'h78;
    ovr[16'h0600] = 8'hF8; ovr[16'h0610] = 8'hF0;
    run_op("R6", 1, 0, 0, 1, 8'h08, 8'h00, 16'h0600, 0);
    run_op("R6", 1, 0, 0, 1, 8'h0F, 8'h00, 16'h0610, 0);
    // R7 and R8: post-indexed with wrap and carry
    ovr[16'h0700] = 8'hFF;
    run_op("R7", 1, 4, 0, 1, 8'h00, 8'h90, 16'h0700, 0);
    run_op("R7", 1, 4, 0, 0, 8'h00, 8'h90, 16'h0700, 0);
    run_op("R7", 1, 4, 0, 1, 8'h00, 8'h01, 16'h0700, 0);
    // R11: start while busy is ignored
    run_op("R11", 1, 3, 0, 1, 8'h00, 8'h00, 16'h0500, 1);
    run_op("R11", 1, 4, 0, 1, 8'h00, 8'h90, 16'h0700, 1);

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule